// File: doc/BRIEF.md
# Serial EEPROM Slave Model (256 x 16)

This block is a synthesizable model of a small serial EEPROM: 256 words of 16 bits behind a three-wire synchronous serial port made of a chip select (`cs`), a serial clock (`sk`) and serial data in (`di`). It returns data, and a ready/busy indication while a word or the whole array is being programmed, on a single data-out pin (`sdo`) that is released to high impedance whenever the block is not driving it. A separate `sdo_oe` output shows when `sdo` is being driven.

The serial pins are brought into the `clk` domain through a synchronizer, and `di` is taken on each detected rising edge of `sk` while `cs` is high. A frame is a start bit, a two-bit opcode and an eight-bit address, followed by sixteen data bits for the two write-type commands that carry data. The storage is an internal register file that reset sets to all ones. Programming is modelled by a timer of `PROG_CYCLES` system clock cycles that starts when `cs` falls after a complete write-type frame.

Control is a single state machine. Its states are IDLE (cs low), HUNT (waiting for the start bit), CMD (shifting opcode and address), WDATA (shifting write data), RDATA (streaming read data), WAIT_CS (frame complete, waiting for cs to fall), PROG (programming timer running) and READY (programming finished, cs still high). Transitions: IDLE to HUNT on cs high; HUNT to CMD on a sampled 1; CMD to RDATA, WDATA or WAIT_CS on the last address bit, depending on the opcode; WDATA to WAIT_CS after the sixteenth data bit; WAIT_CS to PROG on cs low if a write is pending, otherwise to IDLE; PROG to READY (cs high) or IDLE (cs low) when the timer ends; READY to CMD on a sampled 1. From every state except PROG, cs low leads to IDLE.

Top module: `serial_eeprom`

## Requirements
- R1: While cs is high, zeros sampled on sk rising edges before the first 1 are ignored. The first sampled 1 is the start bit.
- R2: After the start bit come a 2-bit opcode and an 8-bit address, both MSB first. Opcode 2'b10 is read, 2'b01 is write and 2'b11 is erase. Opcode 2'b00 uses address bits [7:6] as a sub-command: 2'b11 enables writes, 2'b00 disables writes, 2'b01 writes all words and 2'b10 erases all words. The address bits [5:0] of a sub-command are ignored.
- R3: For a read, sdo is driven to 0 as a dummy bit on the sk edge that takes address bit 0. On each following sk rising edge it presents the next bit of the word, D15 first and D0 last.
- R4: If sk keeps running with cs high, the read continues with the next higher address after D0, and the address wraps from 255 to 0.
- R5: After reset every word reads 16'hFFFF, writes are disabled and sdo is not driven.
- R6: The write-enable state persists until a disable sub-command or a reset. While writes are disabled, write, erase, write-all and erase-all leave the array unchanged, and reads still work.
- R7: A write takes 16 data bits, D15 first, after the address. The word changes only when cs falls after all 16 bits. If cs falls before the frame is complete, nothing is written.
- R8: Erase sets the addressed word to 16'hFFFF. Erase-all sets every word to 16'hFFFF. Write-all stores its 16 data bits in every word within one programming cycle.
- R9: While programming runs and cs is high, sdo is driven 0 (busy). Once programming ends, sdo is driven 1 (ready) until cs falls or a new start bit arrives.
- R10: Bits clocked in while programming runs are ignored, so a command sent during busy has no effect.
- R11: sdo is high impedance while cs is low, while the block waits for a start bit and while it takes in opcode and address bits.
- R12: Programming cannot be cancelled by cs. Ready appears `PROG_CYCLES` system clock cycles after programming starts, allowing a few cycles for synchronizer delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the serial pins are sampled in this domain |
| rst_n | input | 1 | Active-low asynchronous reset, standing in for power-on |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock; its rising edges take in and put out bits |
| di | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out or ready/busy; high impedance when not driven |
| sdo_oe | output | 1 | High while sdo is being driven |

## Verification
The hardest situation to reach is a command arriving while programming is still running, because it needs cs raised again after the frame that started programming and a full frame clocked in before the timer ends. The bench raises cs right after a write, checks for busy, and clocks in a complete write-disable frame during the busy window. It then waits for ready, measures the programming time against `PROG_CYCLES`, and proves that the disable was ignored by completing a later write. A read that runs across address 255 and a write frame cut short by cs are set up directly. Random command sequences with random leading zeros then mix the remaining orderings, and every result is compared with a word-level model kept in the bench.

// File: rtl/seep_pkg.sv
package seep_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HUNT,
        ST_CMD,
        ST_WDATA,
        ST_RDATA,
        ST_WAIT_CS,
        ST_PROG,
        ST_READY
    } seep_state_e;

    typedef enum logic [1:0] {
        PK_WRITE,
        PK_ERASE,
        PK_WRALL,
        PK_ERALL
    } prog_kind_e;

    localparam logic [1:0] OPC_SPECIAL = 2'b00;
    localparam logic [1:0] OPC_WRITE   = 2'b01;
    localparam logic [1:0] OPC_READ    = 2'b10;
    localparam logic [1:0] OPC_ERASE   = 2'b11;

    localparam logic [1:0] SUB_WDIS  = 2'b00;
    localparam logic [1:0] SUB_WRALL = 2'b01;
    localparam logic [1:0] SUB_ERALL = 2'b10;
    localparam logic [1:0] SUB_WEN   = 2'b11;

endpackage

// File: rtl/seep_pin_sync.sv
module seep_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sk,
    input  logic di,
    output logic cs_s,
    output logic sk_rise,
    output logic di_s
);
    // each stage holds {cs, sk, di}
    logic [STAGES-1:0][2:0] stg_q;
    logic                   sk_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q     <= '0;
            sk_prev_q <= 1'b0;
        end else begin
            stg_q     <= {stg_q[STAGES-2:0], {cs, sk, di}};
            sk_prev_q <= stg_q[STAGES-1][1];
        end
    end

    assign cs_s    = stg_q[STAGES-1][2];
    assign di_s    = stg_q[STAGES-1][0];
    assign sk_rise = stg_q[STAGES-1][1] & ~sk_prev_q;

endmodule

// File: rtl/seep_prog_timer.sv
module seep_prog_timer #(
    parameter int PROG_CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(PROG_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(PROG_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            cnt_q <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            cnt_q <= '0;
        end else if (busy) begin
            if (cnt_q == LAST) begin
                busy <= 1'b0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign done = busy && (cnt_q == LAST);

    // R12: a cycle that is running is never restarted
    a_r12_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);

    // R12: the cycle ends exactly once, then the timer is idle
    a_r12_done_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

endmodule

// File: rtl/seep_array.sv
module seep_array
    import seep_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  prog_kind_e        kind,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DEPTH*DATA_W-1:0] flat;
    logic                    all_words;
    logic                    erasing;

    assign all_words = (kind == PK_WRALL) || (kind == PK_ERALL);
    assign erasing   = (kind == PK_ERASE) || (kind == PK_ERALL);

    for (genvar w = 0; w < DEPTH; w++) begin : g_word
        logic [DATA_W-1:0] word_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= '1;
            end else if (commit && (all_words || waddr == ADDR_W'(w))) begin
                word_q <= erasing ? '1 : wdata;
            end
        end

        assign flat[w*DATA_W +: DATA_W] = word_q;
    end

    assign rdata = flat[raddr*DATA_W +: DATA_W];

endmodule

// File: rtl/seep_ctrl.sv
module seep_ctrl
    import seep_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_s,
    input  logic              sk_rise,
    input  logic              di_s,
    input  logic              prog_busy,
    input  logic              prog_done,
    output logic              prog_start,
    output prog_kind_e        pend_kind,
    output logic [ADDR_W-1:0] pend_addr,
    output logic [DATA_W-1:0] pend_data,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_word,
    output logic              sdo_oe,
    output logic              sdo_val
);
    localparam int CMD_BITS = 2 + ADDR_W;
    localparam int MAXB     = (CMD_BITS > DATA_W) ? CMD_BITS : DATA_W;
    localparam int CNT_W    = $clog2(MAXB);
    localparam int BIT_W    = $clog2(DATA_W);

    seep_state_e state_q, state_d;

    logic [CMD_BITS-2:0] sh_q;
    logic [DATA_W-2:0]   dat_q;
    logic [CNT_W-1:0]    bit_cnt_q;
    logic [BIT_W-1:0]    rd_cnt_q;
    logic                rd_bit_q;
    logic                wen_q;
    logic                pend_valid_q;

    logic                sk_act;
    logic [CMD_BITS-1:0] full;
    logic [1:0]          opc;
    logic [1:0]          sub;
    logic [ADDR_W-1:0]   addr;
    logic                cmd_last;
    logic                data_last;
    logic                start_hit;
    logic                takes_data;

    assign sk_act     = sk_rise && cs_s;
    assign full       = {sh_q, di_s};
    assign opc        = full[CMD_BITS-1 -: 2];
    assign sub        = full[ADDR_W-1 -: 2];
    assign addr       = full[ADDR_W-1:0];
    assign cmd_last   = (state_q == ST_CMD) && sk_act && (bit_cnt_q == CNT_W'(CMD_BITS - 1));
    assign data_last  = (state_q == ST_WDATA) && sk_act && (bit_cnt_q == CNT_W'(DATA_W - 1));
    assign start_hit  = ((state_q == ST_HUNT) || (state_q == ST_READY)) && sk_act && di_s;
    assign takes_data = (opc == OPC_WRITE) || ((opc == OPC_SPECIAL) && (sub == SUB_WRALL));
    assign prog_start = (state_q == ST_WAIT_CS) && !cs_s && pend_valid_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (cs_s) state_d = ST_HUNT;
            ST_HUNT:    if (!cs_s) state_d = ST_IDLE;
                        else if (start_hit) state_d = ST_CMD;
            ST_CMD:     if (!cs_s) state_d = ST_IDLE;
                        else if (cmd_last) begin
                            if (opc == OPC_READ) state_d = ST_RDATA;
                            else if (takes_data) state_d = ST_WDATA;
                            else state_d = ST_WAIT_CS;
                        end
            ST_WDATA:   if (!cs_s) state_d = ST_IDLE;
                        else if (data_last) state_d = ST_WAIT_CS;
            ST_RDATA:   if (!cs_s) state_d = ST_IDLE;
            ST_WAIT_CS: if (!cs_s) state_d = pend_valid_q ? ST_PROG : ST_IDLE;
            ST_PROG:    if (prog_done) state_d = cs_s ? ST_READY : ST_IDLE;
            ST_READY:   if (!cs_s) state_d = ST_IDLE;
                        else if (start_hit) state_d = ST_CMD;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // shift registers, write-enable latch, pending programming request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q         <= '0;
            dat_q        <= '0;
            bit_cnt_q    <= '0;
            rd_cnt_q     <= '0;
            rd_bit_q     <= 1'b0;
            rd_addr      <= '0;
            wen_q        <= 1'b0;
            pend_valid_q <= 1'b0;
            pend_kind    <= PK_WRITE;
            pend_addr    <= '0;
            pend_data    <= '0;
        end else begin
            if (state_q == ST_IDLE || prog_done) pend_valid_q <= 1'b0;
            if (start_hit) begin
                sh_q      <= '0;
                bit_cnt_q <= '0;
            end
            if (state_q == ST_CMD && sk_act) begin
                sh_q      <= full[CMD_BITS-2:0];
                bit_cnt_q <= bit_cnt_q + 1'b1;
                if (cmd_last) begin
                    bit_cnt_q <= '0;
                    pend_addr <= addr;
                    unique case (opc)
                        OPC_READ: begin
                            rd_addr  <= addr;
                            rd_cnt_q <= '0;
                            rd_bit_q <= 1'b0;
                        end
                        OPC_WRITE: pend_kind <= PK_WRITE;
                        OPC_ERASE: begin
                            pend_kind    <= PK_ERASE;
                            pend_valid_q <= wen_q;
                        end
                        OPC_SPECIAL: begin
                            unique case (sub)
                                SUB_WEN:   wen_q <= 1'b1;
                                SUB_WDIS:  wen_q <= 1'b0;
                                SUB_WRALL: pend_kind <= PK_WRALL;
                                SUB_ERALL: begin
                                    pend_kind    <= PK_ERALL;
                                    pend_valid_q <= wen_q;
                                end
                                default: ;
                            endcase
                        end
                        default: ;
                    endcase
                end
            end
            if (state_q == ST_WDATA && sk_act) begin
                dat_q     <= {dat_q[DATA_W-3:0], di_s};
                bit_cnt_q <= bit_cnt_q + 1'b1;
                if (data_last) begin
                    pend_data    <= {dat_q, di_s};
                    pend_valid_q <= wen_q;
                end
            end
            if (state_q == ST_RDATA && sk_act) begin
                rd_bit_q <= rd_word[BIT_W'(DATA_W - 1) - rd_cnt_q];
                if (rd_cnt_q == BIT_W'(DATA_W - 1)) begin
                    rd_cnt_q <= '0;
                    rd_addr  <= rd_addr + 1'b1;
                end else begin
                    rd_cnt_q <= rd_cnt_q + 1'b1;
                end
            end
        end
    end

    // outputs
    always_comb begin
        sdo_oe  = 1'b0;
        sdo_val = 1'b0;
        unique case (state_q)
            ST_RDATA: begin sdo_oe = cs_s; sdo_val = rd_bit_q; end
            ST_PROG:  begin sdo_oe = cs_s; sdo_val = 1'b0;     end
            ST_READY: begin sdo_oe = cs_s; sdo_val = 1'b1;     end
            default:  ;
        endcase
    end

    // R10: while the state machine sits in programming, the timer is running
    a_r10_prog_tracks_timer: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROG) |-> prog_busy);

    // R12: programming is left only when the timer reports completion
    a_r12_prog_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROG && !prog_done) |=> (state_q == ST_PROG));

    // R6: no array update completes unless writes are enabled
    a_r6_commit_needs_wen: assert property (@(posedge clk) disable iff (!rst_n)
        prog_done |-> wen_q);

    // R4: during a read stream the address only ever steps up by one
    a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RDATA && $past(state_q) == ST_RDATA && rd_addr != $past(rd_addr))
        |-> rd_addr == $past(rd_addr) + 1'b1);

endmodule

// File: rtl/serial_eeprom.sv
module serial_eeprom
    import seep_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 16,
    parameter int PROG_CYCLES = 2000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sk,
    input  logic di,
    output wire  sdo,
    output logic sdo_oe
);
    logic              cs_s, sk_rise, di_s;
    logic              prog_start, prog_busy, prog_done;
    prog_kind_e        pend_kind;
    logic [ADDR_W-1:0] pend_addr, rd_addr;
    logic [DATA_W-1:0] pend_data, rd_word;
    logic              sdo_val;

    seep_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di),
        .cs_s(cs_s), .sk_rise(sk_rise), .di_s(di_s)
    );

    seep_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .sk_rise(sk_rise), .di_s(di_s),
        .prog_busy(prog_busy), .prog_done(prog_done), .prog_start(prog_start),
        .pend_kind(pend_kind), .pend_addr(pend_addr), .pend_data(pend_data),
        .rd_addr(rd_addr), .rd_word(rd_word), .sdo_oe(sdo_oe), .sdo_val(sdo_val)
    );

    seep_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(prog_start), .busy(prog_busy), .done(prog_done)
    );

    seep_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk(clk), .rst_n(rst_n), .commit(prog_done), .kind(pend_kind),
        .waddr(pend_addr), .wdata(pend_data), .raddr(rd_addr), .rdata(rd_word)
    );

    assign sdo = sdo_oe ? sdo_val : 1'bz;

endmodule

// File: tb/serial_eeprom_tb.sv
module serial_eeprom_tb;
    localparam int PROGC = 400;
    localparam int HALF  = 6;
    localparam int WD    = 190000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0, sk = 1'b0, di = 1'b0;
    wire  sdo;
    logic sdo_oe;

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit finished = 1'b0;
    logic s_do, s_oe;
    logic [15:0] ref_mem [256];
    bit ref_wen;

    always #5 clk = ~clk;
    always @(posedge clk) cyc++;

    serial_eeprom #(.PROG_CYCLES(PROGC)) u_dut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di), .sdo(sdo), .sdo_oe(sdo_oe)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic sk_bit(input logic b);
        di = b;
        repeat (HALF) @(negedge clk);
        sk = 1'b1;
        repeat (HALF) @(negedge clk);
        s_do = sdo;
        s_oe = sdo_oe;
        sk = 1'b0;
    endtask

    task automatic send_bits(input logic [15:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) sk_bit(v[i]);
    endtask

    task automatic frame(input int nz, input logic [1:0] op, input logic [7:0] a);
        cs = 1'b1;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nz; i++) sk_bit(1'b0);
        sk_bit(1'b1);
        sk_bit(op[1]);
        chk("R11 hi-z during opcode", {31'd0, s_oe}, 32'd0);
        sk_bit(op[0]);
        send_bits({8'd0, a}, 8);
    endtask

    task automatic cs_low();
        cs = 1'b0;
        di = 1'b0;
        repeat (HALF + 2) @(negedge clk);
    endtask

    task automatic rd_words(input logic [7:0] a, input int n, input int nz, input string tag0);
        logic [15:0] w;
        frame(nz, 2'b10, a);
        chk("R3 dummy zero", {30'd0, s_oe, s_do}, 32'd2);
        for (int k = 0; k < n; k++) begin
            w = '0;
            for (int b = 0; b < 16; b++) begin
                sk_bit(1'b0);
                w = {w[14:0], s_do};
            end
            chk((k == 0) ? tag0 : "R4 auto-increment", {16'd0, w}, {16'd0, ref_mem[8'(a + k)]});
        end
        cs_low();
        chk("R11 hi-z after cs low", {31'd0, sdo_oe}, 32'd0);
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d, input int nz);
        frame(nz, 2'b01, a);
        send_bits(d, 16);
        cs_low();
        if (ref_wen) ref_mem[a] = d;
        repeat (PROGC + 10) @(negedge clk);
    endtask

    task automatic er(input logic [7:0] a);
        frame(0, 2'b11, a);
        cs_low();
        if (ref_wen) ref_mem[a] = 16'hFFFF;
        repeat (PROGC + 10) @(negedge clk);
    endtask

    task automatic special(input logic [1:0] sb, input logic [15:0] d);
        frame(0, 2'b00, {sb, 6'b101010});
        if (sb == 2'b01) send_bits(d, 16);
        cs_low();
        if (sb == 2'b11) ref_wen = 1'b1;
        if (sb == 2'b00) ref_wen = 1'b0;
        if (ref_wen && sb == 2'b01) for (int i = 0; i < 256; i++) ref_mem[i] = d;
        if (ref_wen && sb == 2'b10) for (int i = 0; i < 256; i++) ref_mem[i] = 16'hFFFF;
        if (sb == 2'b01 || sb == 2'b10) repeat (PROGC + 10) @(negedge clk);
    endtask

    task automatic wr_status(input logic [7:0] a, input logic [15:0] d);
        int t0, guard;
        frame(0, 2'b01, a);
        send_bits(d, 16);
        cs = 1'b0;
        di = 1'b0;
        t0 = cyc;
        repeat (HALF) @(negedge clk);
        cs = 1'b1;
        repeat (HALF) @(negedge clk);
        chk("R9 busy shown", {30'd0, sdo_oe, sdo}, 32'd2);
        // a write-disable frame sent while busy must be ignored (R10)
        sk_bit(1'b1);
        send_bits(16'd0, 10);
        chk("R10 still busy after frame", {30'd0, sdo_oe, sdo}, 32'd2);
        guard = 0;
        while (!(sdo_oe === 1'b1 && sdo === 1'b1) && guard < 4000) begin
            @(negedge clk);
            guard++;
        end
        chk("R9 ready shown", {30'd0, sdo_oe, sdo}, 32'd3);
        chk("R12 programming length", {31'd0, (cyc - t0 >= PROGC) && (cyc - t0 <= PROGC + 8)}, 32'd1);
        cs_low();
        ref_mem[a] = d;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) ref_mem[i] = 16'hFFFF;
        ref_wen = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R5 sdo released after reset", {31'd0, sdo_oe}, 32'd0);

        rd_words(8'h10, 1, 3, "R1 leading zeros / R5 erased");
        wr(8'h10, 16'h1234, 0);
        rd_words(8'h10, 1, 0, "R6 write ignored when disabled");
        special(2'b11, 16'h0);
        wr(8'h10, 16'hA5C3, 2);
        rd_words(8'h10, 1, 0, "R7 write stored");
        rd_words(8'h10, 1, 0, "R2 read opcode");

        wr_status(8'h20, 16'h0F0F);
        wr(8'h21, 16'h5678, 0);
        rd_words(8'h20, 2, 0, "R10 write during busy");

        frame(0, 2'b01, 8'h10);
        send_bits(16'h00FF, 7);
        cs_low();
        repeat (PROGC + 10) @(negedge clk);
        rd_words(8'h10, 1, 0, "R7 aborted frame writes nothing");

        er(8'h20);
        rd_words(8'h20, 1, 0, "R8 erase word");

        wr(8'hFF, 16'hBEEF, 0);
        wr(8'h00, 16'hC0DE, 0);
        rd_words(8'hFE, 3, 1, "R4 wrap start");

        frame(0, 2'b10, 8'h30);
        send_bits(16'h0, 5);
        cs_low();
        chk("R11 read aborted", {31'd0, sdo_oe}, 32'd0);
        rd_words(8'hFF, 2, 0, "R3 read after abort");

        special(2'b01, 16'h1111);
        rd_words(8'h7C, 2, 0, "R8 write-all");
        special(2'b10, 16'h0);
        rd_words(8'h33, 1, 0, "R8 erase-all");
        wr(8'h44, 16'h4444, 0);
        special(2'b00, 16'h0);
        wr(8'h44, 16'h9999, 0);
        er(8'h44);
        special(2'b10, 16'h0);
        rd_words(8'h44, 1, 0, "R6 disabled write/erase ignored");

        for (int it = 0; it < 30; it++) begin
            int k;
            logic [7:0] a;
            logic [15:0] d;
            k = int'($urandom % 10);
            a = 8'($urandom);
            d = 16'($urandom);
            case (k)
                0, 1, 2: rd_words(a, 1 + int'($urandom % 3), int'($urandom % 4), "R2 random read");
                3, 4:    wr(a, d, int'($urandom % 3));
                5:       er(a);
                6, 7:    special(2'b11, 16'h0);
                8:       special(2'b00, 16'h0);
                default: special(($urandom % 2) ? 2'b01 : 2'b10, d);
            endcase
        end
        rd_words(8'h00, 2, 0, "R2 final read");

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (WD) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog (all requirements) actual=hung expected=complete");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule